// File: doc/BRIEF.md
# FIFO Service Selector

This block picks the next FIFO for a memory sequencer to service while that sequencer checks its data queues. It watches the empty flags of a group of write-data FIFOs and a group of read-data FIFOs. Each flag is active high, so a 1 means that FIFO is empty. When the sequencer pulses a check strobe, the block takes a copy of both flag vectors. It then runs one priority chain over all of them and raises a single active bit for the winning FIFO. A one-cycle valid pulse marks the decision, together with a command code and a command enable.

The write group always ranks above the read group. Inside each group, the lowest index ranks highest. The default build has three write FIFOs and two read FIFOs, so the order is write 0, write 1, write 2, read 0, read 1. Both group sizes are parameters.

Control is a three-state machine.
- `ST_IDLE`: waiting for a check.
- `ST_CLEAR`: the active outputs are cleared and the flags are held in a copy.
- `ST_LOAD`: the chosen bit and the valid pulse are on the outputs.

The transitions are:
- `IDLE->CLEAR` when the strobe is high.
- `CLEAR->LOAD` always.
- `LOAD->IDLE` always.

Top module: `fifo_svc_sel`

## Requirements
- R1: After reset, both active vectors are zero, valid and command enable are low, and the command output is 3'b111.
- R2: A strobe sampled high in `ST_IDLE` clears both active vectors and sets the command to 3'b111 in the next cycle. The decision appears in the cycle after that.
- R3: No more than one bit is set across the write and read active vectors together.
- R4: If any write FIFO is non-empty (empty flag 0), the lowest-index non-empty write FIFO gets the only active bit. Active bit i of the write vector stands for write FIFO i, and the read vector is all zero.
- R5: If every write FIFO is empty, the lowest-index non-empty read FIFO gets the only active bit. Active bit i of the read vector stands for read FIFO i.
- R6: If every FIFO is empty at the check, no active bit is set, valid and command enable stay low, and the command stays 3'b111.
- R7: Valid and command enable are high together for exactly one cycle per decision. During that cycle the command is 3'b000 for a write pick and 3'b001 for a read pick. At all other times it is 3'b111.
- R8: The decision uses the empty flags present at the strobe edge. Flag changes after that edge do not alter it.
- R9: A strobe seen while in `ST_CLEAR` or `ST_LOAD` is ignored, so a strobe held high for three cycles gives exactly one decision.
- R10: After the valid pulse, the active vectors keep the decision until the next accepted strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| check_i | input | 1 | Check strobe from the sequencer's data-check state |
| wr_empty_i | input | NUM_WR | Write FIFO empty flags, 1 = empty |
| rd_empty_i | input | NUM_RD | Read FIFO empty flags, 1 = empty |
| wr_active_o | output | NUM_WR | One-hot write service flag |
| rd_active_o | output | NUM_RD | One-hot read service flag |
| pick_valid_o | output | 1 | One-cycle pulse marking a decision |
| cmd_o | output | 3 | 3'b000 write, 3'b001 read, 3'b111 none |
| cmd_en_o | output | 1 | Command enable, pulses with valid |

## Verification
Hand-picked flag patterns test how the chain ranks FIFOs against each other:
- Only one non-empty FIFO in a group checks the index mapping.
- Several non-empty FIFOs check lowest-index priority.
- Write FIFOs that are all empty while reads are pending checks the hand-over from the write group to the read group.
- An all-empty pattern checks that no decision is made.

A sweep over all 32 flag combinations then compares every result against the ranking rule.

Two more patterns test timing rather than ranking. Flipping the flags right after the strobe separates a design that samples at the strobe from one that looks at live inputs. Holding the strobe high across the busy states separates a design that gives one decision per check from one that restarts.

// File: rtl/svc_sel_pkg.sv
package svc_sel_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLEAR = 2'd1,
        ST_LOAD  = 2'd2
    } sel_state_t;

    localparam logic [2:0] CMD_NONE  = 3'b111;
    localparam logic [2:0] CMD_WRITE = 3'b000;
    localparam logic [2:0] CMD_READ  = 3'b001;

endpackage

// File: rtl/svc_prio_chain.sv
// First-match priority chain: index 0 has the highest rank.
module svc_prio_chain #(
    parameter int WIDTH = 5
) (
    input  logic [WIDTH-1:0] req_i,
    output logic [WIDTH-1:0] gnt_o,
    output logic             hit_o
);

    logic found;

    always_comb begin
        gnt_o = '0;
        found = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            if (!found && req_i[i]) begin
                gnt_o[i] = 1'b1;
                found    = 1'b1;
            end
        end
        hit_o = found;
    end

endmodule

// File: rtl/svc_sel_fsm.sv
module svc_sel_fsm
    import svc_sel_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       check_i,
    output sel_state_t state_o,
    output logic       accept_o
);

    sel_state_t state_q;
    sel_state_t state_d;

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_IDLE;
        else       state_q <= state_d;
    end

    // Next state and accept decode
    always_comb begin
        state_d  = state_q;
        accept_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (check_i) begin
                    state_d  = ST_CLEAR;
                    accept_o = 1'b1;
                end
            end
            ST_CLEAR: state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    assign state_o = state_q;

    // R9: a busy state never leads straight into a new clear
    p_busy_ignores_strobe_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q != ST_IDLE) |=> (state_q != ST_CLEAR));

endmodule

// File: rtl/svc_sel_out.sv
module svc_sel_out
    import svc_sel_pkg::*;
#(
    parameter int NUM_WR = 3,
    parameter int NUM_RD = 2
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  sel_state_t               state_i,
    input  logic                     accept_i,
    input  logic [NUM_WR+NUM_RD-1:0] gnt_i,
    input  logic                     hit_i,
    output logic [NUM_WR-1:0]        wr_active_o,
    output logic [NUM_RD-1:0]        rd_active_o,
    output logic                     valid_o,
    output logic                     cmd_en_o,
    output logic [2:0]               cmd_o
);

    localparam int NUM_ALL = NUM_WR + NUM_RD;

    logic [NUM_WR-1:0] gnt_wr;
    logic [NUM_RD-1:0] gnt_rd;

    assign gnt_wr = gnt_i[NUM_WR-1:0];
    assign gnt_rd = gnt_i[NUM_ALL-1:NUM_WR];

    // Output register process
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            wr_active_o <= '0;
            rd_active_o <= '0;
            valid_o     <= 1'b0;
            cmd_en_o    <= 1'b0;
            cmd_o       <= CMD_NONE;
        end else begin
            unique case (state_i)
                ST_IDLE: begin
                    if (accept_i) begin
                        wr_active_o <= '0;
                        rd_active_o <= '0;
                        valid_o     <= 1'b0;
                        cmd_en_o    <= 1'b0;
                        cmd_o       <= CMD_NONE;
                    end
                end
                ST_CLEAR: begin
                    wr_active_o <= gnt_wr;
                    rd_active_o <= gnt_rd;
                    valid_o     <= hit_i;
                    cmd_en_o    <= hit_i;
                    if (!hit_i)       cmd_o <= CMD_NONE;
                    else if (|gnt_wr) cmd_o <= CMD_WRITE;
                    else              cmd_o <= CMD_READ;
                end
                default: begin
                    valid_o  <= 1'b0;
                    cmd_en_o <= 1'b0;
                    cmd_o    <= CMD_NONE;
                end
            endcase
        end
    end

    // R3: one service flag at most
    p_one_active_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({rd_active_o, wr_active_o}));

    // R2: outputs are empty while the clear state is held
    p_clear_first_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == ST_CLEAR) |-> ({rd_active_o, wr_active_o} == '0));

    // R6: a valid decision always carries a flag and an enable
    p_valid_has_pick_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> ((|{rd_active_o, wr_active_o}) && cmd_en_o));

    // R7: single-cycle pulse
    p_valid_pulse_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |=> !valid_o);

    // R7: idle command outside the pulse
    p_idle_cmd_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_o |-> (cmd_o == CMD_NONE && !cmd_en_o));

    // R10: flags hold while idle and no strobe is accepted
    p_hold_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == ST_IDLE && !accept_i) |=>
            ($stable(wr_active_o) && $stable(rd_active_o)));

endmodule

// File: rtl/fifo_svc_sel.sv
module fifo_svc_sel
    import svc_sel_pkg::*;
#(
    parameter int NUM_WR = 3,
    parameter int NUM_RD = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              check_i,
    input  logic [NUM_WR-1:0] wr_empty_i,
    input  logic [NUM_RD-1:0] rd_empty_i,
    output logic [NUM_WR-1:0] wr_active_o,
    output logic [NUM_RD-1:0] rd_active_o,
    output logic              pick_valid_o,
    output logic [2:0]        cmd_o,
    output logic              cmd_en_o
);

    localparam int NUM_ALL = NUM_WR + NUM_RD;

    sel_state_t         state;
    logic               accept;
    logic [NUM_ALL-1:0] empty_snap;
    logic [NUM_ALL-1:0] req;
    logic [NUM_ALL-1:0] gnt;
    logic               hit;

    svc_sel_fsm u_fsm (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .check_i  (check_i),
        .state_o  (state),
        .accept_o (accept)
    );

    // Write flags take the low indices, so they outrank every read flag
    always_ff @(posedge clk_i) begin
        if (rst_i)       empty_snap <= '1;
        else if (accept) empty_snap <= {rd_empty_i, wr_empty_i};
    end

    assign req = ~empty_snap;

    svc_prio_chain #(.WIDTH(NUM_ALL)) u_chain (
        .req_i (req),
        .gnt_o (gnt),
        .hit_o (hit)
    );

    svc_sel_out #(.NUM_WR(NUM_WR), .NUM_RD(NUM_RD)) u_out (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .state_i     (state),
        .accept_i    (accept),
        .gnt_i       (gnt),
        .hit_i       (hit),
        .wr_active_o (wr_active_o),
        .rd_active_o (rd_active_o),
        .valid_o     (pick_valid_o),
        .cmd_en_o    (cmd_en_o),
        .cmd_o       (cmd_o)
    );

    // R4: a pending write keeps every read grant off
    p_write_first_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (|req[NUM_WR-1:0]) |-> (gnt[NUM_ALL-1:NUM_WR] == '0));

    // R4, R5: a grant only lands on a requesting FIFO
    p_grant_on_req_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        ((gnt & ~req) == '0) && (hit == (|req)));

endmodule

// File: tb/tb_fifo_svc_sel.sv
module tb_fifo_svc_sel;

    localparam int CLK_PERIOD = 10;
    localparam int NW = 3;
    localparam int NR = 2;

    typedef struct {
        logic [9:0] val;
        string      tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          chk = 1'b0;
    logic [NW-1:0] wr_e = '1;
    logic [NR-1:0] rd_e = '1;
    logic [NW-1:0] wr_act;
    logic [NR-1:0] rd_act;
    logic          valid;
    logic [2:0]    cmd;
    logic          cmd_en;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   done     = 1'b0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo_svc_sel #(.NUM_WR(NW), .NUM_RD(NR)) dut (
        .clk_i        (clk),
        .rst_i        (rst),
        .check_i      (chk),
        .wr_empty_i   (wr_e),
        .rd_empty_i   (rd_e),
        .wr_active_o  (wr_act),
        .rd_active_o  (rd_act),
        .pick_valid_o (valid),
        .cmd_o        (cmd),
        .cmd_en_o     (cmd_en)
    );

    // Observed outputs packed as {valid, cmd_en, cmd, rd, wr}
    function automatic logic [9:0] obs();
        return {valid, cmd_en, cmd, rd_act, wr_act};
    endfunction

    task automatic check(input logic [9:0] act, input logic [9:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Model of the ranking rule, built from the requirements
    function automatic logic [9:0] model(input logic [NW-1:0] we, input logic [NR-1:0] re);
        for (int i = 0; i < NW; i++)
            if (!we[i]) return {2'b11, 3'b000, {NR{1'b0}}, NW'(1 << i)};
        for (int i = 0; i < NR; i++)
            if (!re[i]) return {2'b11, 3'b001, NR'(1 << i), {NW{1'b0}}};
        return {2'b00, 3'b111, {NR{1'b0}}, {NW{1'b0}}};
    endfunction

    // Driver: raises the strobe, pushes the expected decision
    task automatic run(input logic [NW-1:0] we, input logic [NR-1:0] re,
                       input int hold, input bit scramble, input string tag);
        exp_t e;
        @(negedge clk);
        wr_e  = we;
        rd_e  = re;
        chk   = 1'b1;
        e.val = model(we, re);
        e.tag = tag;
        q.push_back(e);
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            if (scramble) begin
                wr_e = ~wr_e;
                rd_e = ~rd_e;
            end
        end
        chk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Monitor: follows each accepted strobe and scores the result
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            if (!rst && chk) begin
                @(negedge clk);
                check(obs(), {2'b00, 3'b111, 5'b0}, "R2 clear before load");
                @(negedge clk);
                if (q.size() == 0) begin
                    n_checks++;
                    n_errors++;
                    $display("FAIL R9: actual=extra decision expected=none");
                end else begin
                    e = q.pop_front();
                    check(obs(), e.val, e.tag);
                    @(posedge clk);
                    @(negedge clk);
                    check(obs(), {2'b00, 3'b111, e.val[4:0]}, "R10/R7 hold after pulse");
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(obs(), {2'b00, 3'b111, 5'b0}, "R1 reset state");
        rst = 1'b0;
        @(negedge clk);
        check(obs(), {2'b00, 3'b111, 5'b0}, "R1 after reset release");

        run(3'b000, 2'b00, 1, 1'b0, "R4 all busy, write 0 wins");
        run(3'b011, 2'b00, 1, 1'b0, "R4 only write 2 non-empty");
        run(3'b101, 2'b00, 1, 1'b0, "R4 write 1 beats reads");
        run(3'b111, 2'b00, 1, 1'b0, "R5 read 0 when writes empty");
        run(3'b111, 2'b01, 1, 1'b0, "R5 read 1 only");
        run(3'b111, 2'b11, 1, 1'b0, "R6 all empty no pick");
        run(3'b110, 2'b11, 1, 1'b1, "R8 flags flipped after strobe");
        run(3'b111, 2'b10, 3, 1'b1, "R9 strobe held three cycles");

        for (int c = 0; c < 32; c++)
            run(c[2:0], c[4:3], 1, 1'b0, "R3 R4 R5 exhaustive sweep");

        repeat (4) @(negedge clk);
        n_checks++;
        if (q.size() != 0) begin
            n_errors++;
            $display("FAIL R9: actual=%0d pending expected=0", q.size());
        end

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule